// File: doc/BRIEF.md
# Power mode control register

An 8-bit special-function register that holds the processor's low-power mode selection together with a few serial and oscillator options. Software reaches it over a simple SFR bus: address, write strobe, write data and a combinational read-data return. The register drives three things. The first is a light-sleep (IDLE) mode output and a deep-sleep (STOP) mode output. The second is a serial baud-doubling enable and a framing-error select fanned out to three serial ports. The third is the oscillator-fail detect enable. It also holds two general-purpose flags and an oscillator-fail flag that only hardware can set.

The sleep modes are tracked by a three-state machine with the states `PM_RUN`, `PM_IDLE` and `PM_STOP`. These are its transitions:
- **go_idle**: RUN to IDLE, on a write with bit 0 set.
- **go_stop**: RUN to STOP, on a write with bit 1 set, provided both CAN controllers are inactive and no IDLE is set or requested.
- **idle_wake**: IDLE to RUN, on any external interrupt request.
- **idle_clear**: IDLE to RUN, on a write with bit 0 clear.
- **stop_wake**: STOP to RUN, on an enabled external interrupt request.
- **reset**: any state to RUN.

Entering STOP sends a one-cycle pulse that clears an external clock-multiplier enable. A STOP request that meets IDLE is refused and reported on an error pulse.

Top module: `pwr_mode_reg`

## Requirements
- R1: After reset, all mode outputs and option outputs are 0, and a read at address 87h returns 00h. A reset during STOP returns the block to RUN.
- R2: A read at address 87h returns the fields in this order: bit 7 baud doubler, bit 6 framing-error select, bit 5 oscillator-fail flag, bit 4 oscillator-fail enable, bit 3 flag GF1, bit 2 flag GF0, bit 1 STOP, bit 0 IDLE. A read at any other address returns 00h, and writes to other addresses change nothing.
- R3: Bit 1 always reads as 0, even while `stop_mode` is 1.
- R4: A write of bit 1 = 1 enters STOP only if both CAN controllers are inactive. A controller is inactive when any of its `can_rst`, `can_swinit` or `can_pdown` bits is 1. Otherwise the STOP request is dropped.
- R5: An accepted STOP write raises `stop_mode` and a one-cycle `clkmul_clr` pulse together, on the clock edge that takes the write.
- R6: STOP is left only when some `ext_irq[i]` and `ext_irq_en[i]` are both 1 (or by reset). Requests that are not enabled, and writes to bits 1:0 while in STOP, have no effect on the mode.
- R7: IDLE is left on any `ext_irq` bit being 1, whether or not it is enabled. In RUN, an interrupt does not block a write that sets IDLE.
- R8: A STOP request made while IDLE is set, or in the same write as bit 0 = 1, produces a one-cycle `stop_err` pulse and does not enter STOP. Bit 0 of that write still selects IDLE.
- R9: The oscillator-fail flag (bit 5) is set by `osc_fail_set`. A software write of 0 clears it, a write of 1 has no effect, and the hardware set wins over a clearing write in the same cycle.
- R10: Bits 7, 6, 4, 3 and 2 are plain read/write bits. `fe_sel` drives bit 6 to all three serial ports, `baud_dbl` follows bit 7 and `ofd_en` follows bit 4.
- R11: A write to bit 0 enters or leaves IDLE from RUN. `idle_mode` and `stop_mode` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, external or internal |
| sfr_addr | input | 8 | SFR address |
| sfr_wr | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for the addressed register |
| can_rst | input | 2 | Per-CAN reset indicator |
| can_swinit | input | 2 | Per-CAN software-init indicator |
| can_pdown | input | 2 | Per-CAN power-down indicator |
| ext_irq | input | 2 | External interrupt requests |
| ext_irq_en | input | 2 | External interrupt enables |
| osc_fail_set | input | 1 | Hardware set for the oscillator-fail flag |
| idle_mode | output | 1 | Light-sleep mode active |
| stop_mode | output | 1 | Deep-sleep mode active |
| baud_dbl | output | 1 | Serial baud doubling enable |
| fe_sel | output | 3 | Framing-error select, one per serial port |
| ofd_en | output | 1 | Oscillator-fail detect enable |
| clkmul_clr | output | 1 | One-cycle clear of the clock-multiplier enable |
| stop_err | output | 1 | One-cycle pulse for a refused STOP-with-IDLE request |

## Verification
The assertions assume that the wake inputs and the CAN status inputs are synchronous to `clk` and stable across each edge. They also assume that `ext_irq_en` qualifies requests in the same cycle. The bench changes every input only on the falling edge. It holds the CAN indicators constant for the whole cycle in which a STOP write is made, so that the quiet condition the checker samples is the one the design sees. Interrupts, STOP writes and IDLE writes are placed in the same cycle only where a requirement defines the result.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_STOP = 2'd2
    } pm_state_e;

    localparam int B_BAUD = 7;
    localparam int B_FESEL = 6;
    localparam int B_OFDF = 5;
    localparam int B_OFDE = 4;
    localparam int B_GF1 = 3;
    localparam int B_GF0 = 2;
    localparam int B_STOP = 1;
    localparam int B_IDLE = 0;
endpackage

// File: rtl/pmr_can_gate.sv
module pmr_can_gate #(
    parameter int NUM_CAN = 2
) (
    input  logic [NUM_CAN-1:0] can_rst,
    input  logic [NUM_CAN-1:0] can_swinit,
    input  logic [NUM_CAN-1:0] can_pdown,
    output logic               all_quiet
);
    logic [NUM_CAN-1:0] quiet;

    for (genvar g = 0; g < NUM_CAN; g++) begin : g_can
        assign quiet[g] = can_rst[g] | can_swinit[g] | can_pdown[g];
    end

    assign all_quiet = &quiet;
endmodule

// File: rtl/pmr_wake.sv
module pmr_wake #(
    parameter int NUM_IRQ = 2
) (
    input  logic [NUM_IRQ-1:0] ext_irq,
    input  logic [NUM_IRQ-1:0] ext_irq_en,
    output logic               any_irq,
    output logic               en_irq
);
    assign any_irq = |ext_irq;
    assign en_irq  = |(ext_irq & ext_irq_en);
endmodule

// File: rtl/pmr_mode_fsm.sv
module pmr_mode_fsm
    import pmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic wr_idle,
    input  logic wr_stop,
    input  logic can_quiet,
    input  logic any_irq,
    input  logic en_irq,
    output logic idle_mode,
    output logic stop_mode,
    output logic clkmul_clr,
    output logic stop_err
);
    pm_state_e state_q, state_d;
    logic      stop_ok;
    logic      stop_bad;
    logic      in_run_or_idle;

    assign in_run_or_idle = (state_q == PM_RUN) || (state_q == PM_IDLE);
    assign stop_bad = wr_hit && wr_stop && in_run_or_idle &&
                      (wr_idle || state_q == PM_IDLE) &&
                      !(state_q == PM_IDLE && any_irq);
    assign stop_ok  = wr_hit && wr_stop && !wr_idle &&
                      state_q == PM_RUN && can_quiet;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_RUN: begin
                if (stop_ok)
                    state_d = PM_STOP;
                else if (wr_hit && wr_idle)
                    state_d = PM_IDLE;
            end
            PM_IDLE: begin
                if (any_irq)
                    state_d = PM_RUN;
                else if (wr_hit && !wr_idle)
                    state_d = PM_RUN;
            end
            PM_STOP: begin
                if (en_irq)
                    state_d = PM_RUN;
            end
            default: state_d = PM_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PM_RUN;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clkmul_clr <= 1'b0;
            stop_err   <= 1'b0;
        end else begin
            clkmul_clr <= (state_q != PM_STOP) && (state_d == PM_STOP);
            stop_err   <= stop_bad;
        end
    end

    assign idle_mode = (state_q == PM_IDLE);
    assign stop_mode = (state_q == PM_STOP);
endmodule

// File: rtl/pwr_mode_reg.sv
module pwr_mode_reg
    import pmr_pkg::*;
#(
    parameter logic [7:0] REG_ADDR = 8'h87,
    parameter int         NUM_CAN  = 2,
    parameter int         NUM_IRQ  = 2,
    parameter int         NUM_SER  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         sfr_addr,
    input  logic               sfr_wr,
    input  logic [7:0]         sfr_wdata,
    output logic [7:0]         sfr_rdata,
    input  logic [NUM_CAN-1:0] can_rst,
    input  logic [NUM_CAN-1:0] can_swinit,
    input  logic [NUM_CAN-1:0] can_pdown,
    input  logic [NUM_IRQ-1:0] ext_irq,
    input  logic [NUM_IRQ-1:0] ext_irq_en,
    input  logic               osc_fail_set,
    output logic               idle_mode,
    output logic               stop_mode,
    output logic               baud_dbl,
    output logic [NUM_SER-1:0] fe_sel,
    output logic               ofd_en,
    output logic               clkmul_clr,
    output logic               stop_err
);
    logic wr_hit;
    logic can_quiet;
    logic any_irq;
    logic en_irq;
    logic baud_q, fesel_q, ofdf_q, ofde_q, gf1_q, gf0_q;

    assign wr_hit = sfr_wr && (sfr_addr == REG_ADDR);

    pmr_can_gate #(.NUM_CAN(NUM_CAN)) u_can (
        .can_rst    (can_rst),
        .can_swinit (can_swinit),
        .can_pdown  (can_pdown),
        .all_quiet  (can_quiet)
    );

    pmr_wake #(.NUM_IRQ(NUM_IRQ)) u_wake (
        .ext_irq    (ext_irq),
        .ext_irq_en (ext_irq_en),
        .any_irq    (any_irq),
        .en_irq     (en_irq)
    );

    pmr_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit     (wr_hit),
        .wr_idle    (sfr_wdata[B_IDLE]),
        .wr_stop    (sfr_wdata[B_STOP]),
        .can_quiet  (can_quiet),
        .any_irq    (any_irq),
        .en_irq     (en_irq),
        .idle_mode  (idle_mode),
        .stop_mode  (stop_mode),
        .clkmul_clr (clkmul_clr),
        .stop_err   (stop_err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            baud_q  <= 1'b0;
            fesel_q <= 1'b0;
            ofde_q  <= 1'b0;
            gf1_q   <= 1'b0;
            gf0_q   <= 1'b0;
        end else if (wr_hit) begin
            baud_q  <= sfr_wdata[B_BAUD];
            fesel_q <= sfr_wdata[B_FESEL];
            ofde_q  <= sfr_wdata[B_OFDE];
            gf1_q   <= sfr_wdata[B_GF1];
            gf0_q   <= sfr_wdata[B_GF0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ofdf_q <= 1'b0;
        else if (osc_fail_set)
            ofdf_q <= 1'b1;
        else if (wr_hit && !sfr_wdata[B_OFDF])
            ofdf_q <= 1'b0;
    end

    always_comb begin
        sfr_rdata = 8'h00;
        if (sfr_addr == REG_ADDR) begin
            sfr_rdata[B_BAUD]  = baud_q;
            sfr_rdata[B_FESEL] = fesel_q;
            sfr_rdata[B_OFDF]  = ofdf_q;
            sfr_rdata[B_OFDE]  = ofde_q;
            sfr_rdata[B_GF1]   = gf1_q;
            sfr_rdata[B_GF0]   = gf0_q;
            sfr_rdata[B_STOP]  = 1'b0;
            sfr_rdata[B_IDLE]  = idle_mode;
        end
    end

    assign baud_dbl = baud_q;
    assign fe_sel   = {NUM_SER{fesel_q}};
    assign ofd_en   = ofde_q;
endmodule

// File: rtl/pmr_checker.sv
module pmr_checker #(
    parameter int NUM_CAN = 2,
    parameter int NUM_IRQ = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [7:0]         sfr_rdata,
    input logic [NUM_CAN-1:0] can_rst,
    input logic [NUM_CAN-1:0] can_swinit,
    input logic [NUM_CAN-1:0] can_pdown,
    input logic [NUM_IRQ-1:0] ext_irq,
    input logic [NUM_IRQ-1:0] ext_irq_en,
    input logic               idle_mode,
    input logic               stop_mode,
    input logic               clkmul_clr,
    input logic               stop_err
);
    logic quiet_now;
    assign quiet_now = &(can_rst | can_swinit | can_pdown);

    p_stop_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_rdata[1] == 1'b0);

    p_stop_needs_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_mode) |-> $past(quiet_now));

    p_clr_on_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_mode) |-> clkmul_clr);

    p_clr_only_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clkmul_clr |-> $rose(stop_mode));

    p_stop_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && !(|(ext_irq & ext_irq_en))) |=> stop_mode);

    p_idle_wakes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_mode && |ext_irq) |=> !idle_mode);

    p_err_no_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_err |-> !stop_mode);

    p_modes_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(idle_mode && stop_mode));
endmodule

bind pwr_mode_reg pmr_checker #(.NUM_CAN(NUM_CAN), .NUM_IRQ(NUM_IRQ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sfr_rdata  (sfr_rdata),
    .can_rst    (can_rst),
    .can_swinit (can_swinit),
    .can_pdown  (can_pdown),
    .ext_irq    (ext_irq),
    .ext_irq_en (ext_irq_en),
    .idle_mode  (idle_mode),
    .stop_mode  (stop_mode),
    .clkmul_clr (clkmul_clr),
    .stop_err   (stop_err)
);

// File: tb/pwr_mode_reg_tb.sv
module pwr_mode_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sfr_addr = 8'h87;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic [1:0] can_rst = 2'b00, can_swinit = 2'b00, can_pdown = 2'b00;
    logic [1:0] ext_irq = 2'b00, ext_irq_en = 2'b00;
    logic       osc_fail_set = 1'b0;
    logic       idle_mode, stop_mode, baud_dbl, ofd_en, clkmul_clr, stop_err;
    logic [2:0] fe_sel;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pwr_mode_reg u_dut (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .can_rst(can_rst), .can_swinit(can_swinit), .can_pdown(can_pdown),
        .ext_irq(ext_irq), .ext_irq_en(ext_irq_en), .osc_fail_set(osc_fail_set),
        .idle_mode(idle_mode), .stop_mode(stop_mode), .baud_dbl(baud_dbl),
        .fe_sel(fe_sel), .ofd_en(ofd_en), .clkmul_clr(clkmul_clr),
        .stop_err(stop_err)
    );

    // can field: {pdown[1:0], swinit[1:0], rst[1:0]}
    // exp field: {rdata[7:0], stop, idle, clr, err}
    typedef struct packed {
        logic [7:0]  addr;
        logic        wr;
        logic [7:0]  wd;
        logic [5:0]  can;
        logic [1:0]  irq;
        logic [1:0]  en;
        logic        ofs;
        logic [11:0] exp;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{8'h87, 1'b1, 8'hCC, 6'b000011, 2'b00, 2'b00, 1'b0, {8'hCC, 4'b0000}}, // R10
        '{8'h87, 1'b1, 8'hFF, 6'b000011, 2'b00, 2'b00, 1'b0, {8'hDD, 4'b0101}}, // R8 R9
        '{8'h87, 1'b0, 8'h00, 6'b000011, 2'b01, 2'b00, 1'b0, {8'hDC, 4'b0000}}, // R7
        '{8'h87, 1'b1, 8'hDE, 6'b000000, 2'b00, 2'b00, 1'b0, {8'hDC, 4'b0000}}, // R4
        '{8'h87, 1'b1, 8'hDE, 6'b000001, 2'b00, 2'b00, 1'b0, {8'hDC, 4'b0000}}, // R4
        '{8'h87, 1'b1, 8'hDE, 6'b100100, 2'b00, 2'b00, 1'b0, {8'hDC, 4'b1010}}, // R3 R4 R5
        '{8'h87, 1'b0, 8'h00, 6'b000000, 2'b00, 2'b00, 1'b0, {8'hDC, 4'b1000}}, // R5
        '{8'h87, 1'b0, 8'h00, 6'b000000, 2'b01, 2'b00, 1'b0, {8'hDC, 4'b1000}}, // R6
        '{8'h87, 1'b1, 8'h00, 6'b000000, 2'b00, 2'b00, 1'b0, {8'h00, 4'b1000}}, // R6
        '{8'h87, 1'b0, 8'h00, 6'b000000, 2'b10, 2'b10, 1'b0, {8'h00, 4'b0000}}, // R6
        '{8'h87, 1'b0, 8'h00, 6'b000000, 2'b00, 2'b00, 1'b1, {8'h20, 4'b0000}}, // R9
        '{8'h87, 1'b1, 8'h00, 6'b000000, 2'b00, 2'b00, 1'b1, {8'h20, 4'b0000}}, // R9
        '{8'h87, 1'b1, 8'h00, 6'b000000, 2'b00, 2'b00, 1'b0, {8'h00, 4'b0000}}, // R9
        '{8'h87, 1'b1, 8'h01, 6'b000011, 2'b00, 2'b00, 1'b0, {8'h01, 4'b0100}}, // R11
        '{8'h87, 1'b1, 8'h02, 6'b000011, 2'b00, 2'b00, 1'b0, {8'h00, 4'b0001}}, // R8
        '{8'h88, 1'b1, 8'hFF, 6'b000011, 2'b00, 2'b00, 1'b0, {8'h00, 4'b0000}}, // R2
        '{8'h87, 1'b0, 8'h00, 6'b000011, 2'b00, 2'b00, 1'b0, {8'h00, 4'b0000}}, // R2
        '{8'h87, 1'b1, 8'h01, 6'b000011, 2'b01, 2'b00, 1'b0, {8'h01, 4'b0100}}, // R7
        '{8'h87, 1'b0, 8'h00, 6'b000011, 2'b10, 2'b00, 1'b0, {8'h00, 4'b0000}}  // R7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic idle_bus();
        sfr_wr = 1'b0; sfr_addr = 8'h87; sfr_wdata = 8'h00;
        ext_irq = 2'b00; ext_irq_en = 2'b00; osc_fail_set = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 rdata", {24'h0, sfr_rdata}, 32'h0);
        check("R1 outs", {26'h0, idle_mode, stop_mode, baud_dbl, ofd_en, clkmul_clr, stop_err}, 32'h0);
        check("R1 fe_sel", {29'h0, fe_sel}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            sfr_addr = VEC[i].addr; sfr_wr = VEC[i].wr; sfr_wdata = VEC[i].wd;
            {can_pdown, can_swinit, can_rst} = VEC[i].can;
            ext_irq = VEC[i].irq; ext_irq_en = VEC[i].en; osc_fail_set = VEC[i].ofs;
            @(negedge clk);
            check($sformatf("vec %0d rdata R2 R3", i), {24'h0, sfr_rdata}, {24'h0, VEC[i].exp[11:4]});
            check($sformatf("vec %0d modes R5 R6 R7 R8 R11", i),
                  {28'h0, stop_mode, idle_mode, clkmul_clr, stop_err}, {28'h0, VEC[i].exp[3:0]});
        end

        // R10: option outputs follow their bits
        idle_bus();
        sfr_wr = 1'b1; sfr_wdata = 8'hD0;
        @(negedge clk);
        idle_bus();
        check("R10 baud_dbl", {31'h0, baud_dbl}, 32'h1);
        check("R10 fe_sel", {29'h0, fe_sel}, 32'h7);
        check("R10 ofd_en", {31'h0, ofd_en}, 32'h1);

        // R1: reset while in STOP returns to RUN and clears bits
        can_rst = 2'b11;
        sfr_wr = 1'b1; sfr_wdata = 8'h02;
        @(negedge clk);
        idle_bus();
        check("R1 stop entered", {31'h0, stop_mode}, 32'h1);
        rst_n = 1'b0;
        #1;
        check("R1 reset in stop", {31'h0, stop_mode}, 32'h0);
        check("R1 reset rdata", {24'h0, sfr_rdata}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {30'h0, stop_mode, idle_mode}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule